// File: doc/BRIEF.md
# Track Fanout with Lookup Reformatting

This block takes a single stream of 21-bit track words, buffers them in an input FIFO and spreads each track to twelve downstream streams. Every track leaves as two words on a shared output bus: first a coarse-bin word for a pattern-matching stage, then the untouched track for a fitting stage. A per-word kind flag tells the two apart, and a per-destination valid vector says which of the twelve streams take the pair.

Two lookup tables are indexed by the same track. One gives a 12-bit coarse bin, which gets a fixed layer tag of 5. The other gives the 12-bit destination enable mask. Both tables, the FIFO head, two spy logs and a sticky error register can be reached over a simple register bus. A run input gates processing. In test mode the engine takes no new tracks, the tables can be written and the FIFO can be drained by hand. Parity errors, FIFO overflow and reserved-code words are flagged.

Top module: `tf_fanout`

## Requirements
- R1: Accepted words leave the FIFO in arrival order. Register select 2 reads the head in bits [20:0] and the empty flag in bit 31. A write to select 2 pops one word, but only in test mode.
- R2: With `run_i` low, no new track starts: `out_valid_o` stays 0 and pending words stay in the FIFO.
- R3: In the first output cycle of a track, `out_kind_o`=0. `out_word_o`[11:0] holds the bin table entry, [14:12] holds 5 and [20:15] holds 0. Both tables are addressed by the low `LUT_AW` bits of the track.
- R4: The cycle after an accepted bin word, `out_kind_o`=1 and `out_word_o` holds the original track, with the same valid vector.
- R5: `out_valid_o` equals the enable table entry for the track during both of its words. With a non-empty FIFO and no hold, tracks follow back to back, one every two cycles.
- R6: While any destination that is enabled for the current track raises `hold_i`, the outputs stay frozen. Hold on a destination that is not enabled has no effect.
- R7: A word whose 21 data bits plus `in_par_i` have odd parity sets status bit 0. The word is still queued.
- R8: A word that arrives while the FIFO is full and not being popped is dropped and sets status bit 1.
- R9: The all-ones word is reserved. It is dropped and sets status bit 2.
- R10: Status bits are sticky and are cleared by a write to select 5 in either mode. A new error in the same cycle as a clear stays set.
- R11: Table writes (select 0 = bin, select 1 = enable) take effect only in test mode. Both tables read back in either mode.
- R12: The input spy (select 3) stores the k-th accepted word in slot k mod depth. The output spy (select 4) stores {mask[26:15], tag[14:12], bin[11:0]} for the k-th started track in slot k mod depth.
- R13: After reset the outputs are idle, the status is 0 and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | 1 = run mode, 0 = test mode |
| in_valid_i | input | 1 | Input word strobe |
| in_data_i | input | 21 | Input track word |
| in_par_i | input | 1 | Even parity bit over the input word |
| hold_i | input | 12 | Per-destination hold |
| out_valid_o | output | 12 | Per-destination word valid |
| out_kind_o | output | 1 | 0 = bin word, 1 = original track |
| out_word_o | output | 21 | Output word shared by all destinations |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Target: 0 bin, 1 enable, 2 FIFO, 3 input spy, 4 output spy, 5 status |
| reg_addr_i | input | 8 | Table or spy address |
| reg_wdata_i | input | 12 | Write data |
| reg_rdata_o | output | 32 | Read data for the current select and address |

## Verification
A status clear and a fresh error can land in the same clock. The bench provokes this by driving a bad-parity word in the very cycle that it writes the clear. It then reads the status back and expects the parity bit to be set. A second directed case raises hold on a destination that is not in the current mask while a track is in flight. Both words must still advance on consecutive cycles.

// File: rtl/tf_pkg.sv
`timescale 1ns/1ps
package tf_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_AM = 2'd1, ST_TF = 2'd2} eng_st_e;

  localparam logic [2:0] SEL_BIN  = 3'd0;
  localparam logic [2:0] SEL_EN   = 3'd1;
  localparam logic [2:0] SEL_FIFO = 3'd2;
  localparam logic [2:0] SEL_SPYI = 3'd3;
  localparam logic [2:0] SEL_SPYO = 3'd4;
  localparam logic [2:0] SEL_STAT = 3'd5;

  localparam int ERR_PAR = 0;
  localparam int ERR_OVF = 1;
  localparam int ERR_INV = 2;
endpackage

// File: rtl/tf_fifo.sv
`timescale 1ns/1ps
module tf_fifo #(
  parameter int W     = 21,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [AW:0]   cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign head_o  = mem_q[rptr_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= wptr_q + 1'b1;
      if (pop_i)  rptr_q <= rptr_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(push_i) - (AW+1)'(pop_i);
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));
  p_no_underflow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/tf_lut.sv
`timescale 1ns/1ps
module tf_lut #(
  parameter int AW = 8,
  parameter int DW = 12
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o
);
  localparam int N = 1 << AW;

  logic [DW-1:0] mem_q [N];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/tf_spy.sv
`timescale 1ns/1ps
module tf_spy #(
  parameter int DW    = 21,
  parameter int DEPTH = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_i,
  output logic [DW-1:0]            rdata_o
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   wptr_q <= '0;
    else if (we_i) wptr_q <= wptr_q + 1'b1;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tf_fanout.sv
`timescale 1ns/1ps
module tf_fanout
  import tf_pkg::*;
#(
  parameter int W          = 21,
  parameter int N_DEST     = 12,
  parameter int SS_W       = 12,
  parameter int TAG_W      = 3,
  parameter int TAG        = 5,
  parameter int LUT_AW     = 8,   // set to W for full-width tables
  parameter int FIFO_DEPTH = 8,
  parameter int SPY_DEPTH  = 16   // log2 must not exceed LUT_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              in_valid_i,
  input  logic [W-1:0]      in_data_i,
  input  logic              in_par_i,
  input  logic [N_DEST-1:0] hold_i,
  output logic [N_DEST-1:0] out_valid_o,
  output logic              out_kind_o,
  output logic [W-1:0]      out_word_o,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [LUT_AW-1:0] reg_addr_i,
  input  logic [(SS_W > N_DEST ? SS_W : N_DEST)-1:0] reg_wdata_i,
  output logic [31:0]       reg_rdata_o
);
  localparam int AM_W   = TAG_W + SS_W;
  localparam int SPYO_W = N_DEST + AM_W;
  localparam int SPY_AW = $clog2(SPY_DEPTH);
  localparam logic [TAG_W-1:0] TAG_V = TAG_W'(TAG);

  // input checks and FIFO write
  logic par_err, inv_word, want_push, fifo_push, fifo_pop, ovf;
  logic fifo_empty, fifo_full;
  logic [W-1:0] fifo_head;
  logic eng_pop, bus_pop;

  assign par_err   = in_valid_i && (^{in_data_i, in_par_i});
  assign inv_word  = in_valid_i && (&in_data_i);
  assign want_push = in_valid_i && !inv_word;
  assign fifo_pop  = eng_pop || bus_pop;
  assign fifo_push = want_push && (!fifo_full || fifo_pop);
  assign ovf       = want_push && fifo_full && !fifo_pop;
  assign bus_pop   = reg_we_i && (reg_sel_i == SEL_FIFO) && !run_i && !fifo_empty;

  tf_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(fifo_push), .data_i(in_data_i), .pop_i(fifo_pop),
    .head_o(fifo_head), .empty_o(fifo_empty), .full_o(fifo_full)
  );

  // lookup tables
  logic [SS_W-1:0]   bin_eng, bin_bus;
  logic [N_DEST-1:0] en_eng, en_bus;
  logic [LUT_AW-1:0] lut_addr;
  assign lut_addr = fifo_head[LUT_AW-1:0];

  tf_lut #(.AW(LUT_AW), .DW(SS_W)) u_bin_lut (
    .clk_i,
    .we_i(reg_we_i && !run_i && (reg_sel_i == SEL_BIN)),
    .waddr_i(reg_addr_i), .wdata_i(reg_wdata_i[SS_W-1:0]),
    .raddr_a_i(lut_addr), .rdata_a_o(bin_eng),
    .raddr_b_i(reg_addr_i), .rdata_b_o(bin_bus)
  );

  tf_lut #(.AW(LUT_AW), .DW(N_DEST)) u_en_lut (
    .clk_i,
    .we_i(reg_we_i && !run_i && (reg_sel_i == SEL_EN)),
    .waddr_i(reg_addr_i), .wdata_i(reg_wdata_i[N_DEST-1:0]),
    .raddr_a_i(lut_addr), .rdata_a_o(en_eng),
    .raddr_b_i(reg_addr_i), .rdata_b_o(en_bus)
  );

  // fanout engine: bin word, then original track
  eng_st_e st_q, st_d;
  logic [W-1:0]      trk_q;
  logic [N_DEST-1:0] mask_q;
  logic [AM_W-1:0]   am_q;
  logic stall, can_start;

  assign stall     = |(hold_i & mask_q);
  assign can_start = run_i && !fifo_empty;

  always_comb begin
    st_d    = st_q;
    eng_pop = 1'b0;
    case (st_q)
      ST_IDLE: if (can_start) begin eng_pop = 1'b1; st_d = ST_AM; end
      ST_AM:   if (!stall) st_d = ST_TF;
      ST_TF:   if (!stall) begin
                 if (can_start) begin eng_pop = 1'b1; st_d = ST_AM; end
                 else st_d = ST_IDLE;
               end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      trk_q  <= '0;
      mask_q <= '0;
      am_q   <= '0;
    end else begin
      st_q <= st_d;
      if (eng_pop) begin
        trk_q  <= fifo_head;
        mask_q <= en_eng;
        am_q   <= {TAG_V, bin_eng};
      end
    end
  end

  assign out_valid_o = (st_q == ST_IDLE) ? '0 : mask_q;
  assign out_kind_o  = (st_q == ST_TF);
  assign out_word_o  = (st_q == ST_TF) ? trk_q :
                       (st_q == ST_AM) ? {{(W-AM_W){1'b0}}, am_q} : '0;

  // spy logs
  logic [W-1:0]      spyi_rd;
  logic [SPYO_W-1:0] spyo_rd;

  tf_spy #(.DW(W), .DEPTH(SPY_DEPTH)) u_spy_in (
    .clk_i, .rst_ni, .we_i(fifo_push), .wdata_i(in_data_i),
    .raddr_i(reg_addr_i[SPY_AW-1:0]), .rdata_o(spyi_rd)
  );

  tf_spy #(.DW(SPYO_W), .DEPTH(SPY_DEPTH)) u_spy_out (
    .clk_i, .rst_ni, .we_i(eng_pop), .wdata_i({en_eng, TAG_V, bin_eng}),
    .raddr_i(reg_addr_i[SPY_AW-1:0]), .rdata_o(spyo_rd)
  );

  // sticky status, set wins over clear
  logic [2:0] stat_q;
  logic       stat_clr;
  assign stat_clr = reg_we_i && (reg_sel_i == SEL_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else begin
      stat_q <= (stat_clr ? 3'b000 : stat_q);
      if (par_err)  stat_q[ERR_PAR] <= 1'b1;
      if (ovf)      stat_q[ERR_OVF] <= 1'b1;
      if (inv_word) stat_q[ERR_INV] <= 1'b1;
    end
  end

  always_comb begin
    case (reg_sel_i)
      SEL_BIN:  reg_rdata_o = {{(32-SS_W){1'b0}}, bin_bus};
      SEL_EN:   reg_rdata_o = {{(32-N_DEST){1'b0}}, en_bus};
      SEL_FIFO: reg_rdata_o = {fifo_empty, {(31-W){1'b0}}, fifo_head};
      SEL_SPYI: reg_rdata_o = {{(32-W){1'b0}}, spyi_rd};
      SEL_SPYO: reg_rdata_o = {{(32-SPYO_W){1'b0}}, spyo_rd};
      SEL_STAT: reg_rdata_o = {29'd0, stat_q};
      default:  reg_rdata_o = '0;
    endcase
  end

  p_hold_freeze_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(hold_i & out_valid_o)) |=> ($stable(out_word_o) && $stable(out_kind_o)
                                  && $stable(out_valid_o)));
  p_tf_follows_am_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|out_valid_o) && !out_kind_o && !(|(hold_i & out_valid_o)))
      |=> (out_kind_o && $stable(out_valid_o)));
  p_no_start_test_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !run_i) |=> (st_q == ST_IDLE));
  p_status_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|stat_q) && !stat_clr) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: tb/sim_tf_fanout.sv
`timescale 1ns/1ps
module sim_tf_fanout;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        in_valid = 1'b0;
  logic [20:0] in_data = '0;
  logic        in_par = 1'b0;
  logic [11:0] hold = '0;
  logic [11:0] out_valid;
  logic        out_kind;
  logic [20:0] out_word;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [7:0]  reg_addr = '0;
  logic [11:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_chk = 0, n_bad = 0, n_in = 0, n_out = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  tf_fanout u0 (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_par_i(in_par),
    .hold_i(hold), .out_valid_o(out_valid), .out_kind_o(out_kind), .out_word_o(out_word),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
  );

  localparam logic [20:0] VEC [8] = '{21'h000000, 21'h0000FF, 21'h1FFFFE, 21'h012345,
                                      21'h00A5A5, 21'h015555, 21'h00AAAA, 21'h100080};

  function automatic logic [11:0] f_bin(input logic [7:0] a);
    return 12'((int'(a) * 37 + 5));
  endfunction
  function automatic logic [11:0] f_en(input logic [7:0] a);
    return 12'((int'(a) * 113)) ^ 12'hA5A;
  endfunction
  function automatic logic [20:0] exp_am(input logic [20:0] t);
    return {6'd0, 3'd5, f_bin(t[7:0])};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] sel, input logic [7:0] a, input logic [11:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] sel, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic push(input logic [20:0] w, input logic bad);
    @(negedge clk);
    in_valid = 1'b1; in_data = w; in_par = (^w) ^ bad;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R13 reset state
    check("R13 idle valid", 32'(out_valid), 32'd0);
    reg_read(3'd5, 8'd0, rd);  check("R13 status", rd, 32'd0);
    reg_read(3'd2, 8'd0, rd);  check("R13 fifo empty", 32'(rd[31]), 32'd1);

    for (int a = 0; a < 256; a++) begin
      reg_write(3'd0, 8'(a), f_bin(8'(a)));
      reg_write(3'd1, 8'(a), f_en(8'(a)));
    end
    reg_read(3'd0, 8'd17, rd);  check("R11 bin readback", rd, 32'(f_bin(8'd17)));
    reg_read(3'd1, 8'd200, rd); check("R11 en readback", rd, 32'(f_en(8'd200)));

    // vector table: one track at a time
    for (int i = 0; i < 8; i++) begin
      push(VEC[i], 1'b0);
      reg_read(3'd3, 8'(n_in % 16), rd);
      check("R12 input spy", rd, 32'(VEC[i]));
      n_in++;
      @(negedge clk); run = 1'b1;
      @(negedge clk); run = 1'b0;
      check("R3 bin word kind", 32'(out_kind), 32'd0);
      check("R3 bin word", 32'(out_word), 32'(exp_am(VEC[i])));
      check("R5 mask", 32'(out_valid), 32'(f_en(VEC[i][7:0])));
      @(negedge clk);
      check("R4 track kind", 32'(out_kind), 32'd1);
      check("R4 track word", 32'(out_word), 32'(VEC[i]));
      check("R5 mask on track word", 32'(out_valid), 32'(f_en(VEC[i][7:0])));
      @(negedge clk);
      check("R5 idle after track", 32'(out_valid), 32'd0);
      reg_read(3'd4, 8'(n_out % 16), rd);
      check("R12 output spy", rd, 32'({f_en(VEC[i][7:0]), 3'd5, f_bin(VEC[i][7:0])}));
      n_out++;
    end

    // R5 back-to-back throughput
    push(21'h000011, 1'b0); push(21'h000022, 1'b0); push(21'h000033, 1'b0);
    @(negedge clk); run = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R5 b2b kind", 32'(out_kind), 32'(k % 2));
      check("R5 b2b mask", 32'(out_valid), 32'(f_en(8'(8'h11 * (k / 2 + 1)))));
    end
    @(negedge clk); run = 1'b0;
    check("R5 b2b drained", 32'(out_valid), 32'd0);

    // R6 hold on disabled destination (mask A5A, bit 0 clear)
    push(21'h000300, 1'b0);
    @(negedge clk); run = 1'b1; hold = 12'h001;
    @(negedge clk); run = 1'b0;
    check("R6 disabled hold bin", 32'(out_kind), 32'd0);
    @(negedge clk);
    check("R6 disabled hold ignored", 32'(out_kind), 32'd1);
    @(negedge clk); hold = 12'h000;
    // R6 hold on enabled destination (bit 1 set)
    push(21'h000400, 1'b0);
    @(negedge clk); run = 1'b1; hold = 12'h002;
    @(negedge clk); run = 1'b0;
    check("R6 held bin word", 32'(out_word), 32'(exp_am(21'h000400)));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R6 frozen kind", 32'(out_kind), 32'd0);
      check("R6 frozen word", 32'(out_word), 32'(exp_am(21'h000400)));
    end
    hold = 12'h000;
    @(negedge clk);
    check("R6 released", 32'(out_word), 32'h000400);
    @(negedge clk);

    // R2 test mode keeps data queued; R1 manual pop
    push(21'h0ABCDE, 1'b0);
    repeat (3) @(negedge clk);
    check("R2 no output in test", 32'(out_valid), 32'd0);
    reg_read(3'd2, 8'd0, rd);
    check("R2 word kept", rd, 32'h000ABCDE);
    reg_write(3'd2, 8'd0, 12'd0);
    reg_read(3'd2, 8'd0, rd);
    check("R1 pop to empty", 32'(rd[31]), 32'd1);

    // R8 overflow, R1 order
    for (int i = 0; i < 9; i++) push(21'(16 + i), 1'b0);
    reg_read(3'd5, 8'd0, rd); check("R8 overflow flag", rd, 32'd2);
    for (int i = 0; i < 8; i++) begin
      reg_read(3'd2, 8'd0, rd);
      check("R1 fifo order", rd, 32'(16 + i));
      reg_write(3'd2, 8'd0, 12'd0);
    end
    reg_read(3'd2, 8'd0, rd); check("R8 ninth dropped", 32'(rd[31]), 32'd1);
    reg_write(3'd5, 8'd0, 12'd0);
    reg_read(3'd5, 8'd0, rd); check("R10 clear", rd, 32'd0);

    // R7 parity
    push(21'h000055, 1'b1);
    reg_read(3'd5, 8'd0, rd); check("R7 parity flag", rd, 32'd1);
    reg_read(3'd2, 8'd0, rd); check("R7 word queued", rd, 32'h00000055);
    reg_write(3'd2, 8'd0, 12'd0);
    reg_write(3'd5, 8'd0, 12'd0);

    // R9 reserved code
    push(21'h1FFFFF, 1'b0);
    reg_read(3'd5, 8'd0, rd); check("R9 invalid flag", rd, 32'd4);
    reg_read(3'd2, 8'd0, rd); check("R9 dropped", 32'(rd[31]), 32'd1);
    reg_write(3'd5, 8'd0, 12'd0);

    // R10 clear and error in the same cycle
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 3'd5;
    in_valid = 1'b1; in_data = 21'h000066; in_par = ~(^21'h000066);
    @(negedge clk);
    reg_we = 1'b0; in_valid = 1'b0;
    reg_read(3'd5, 8'd0, rd); check("R10 set beats clear", rd, 32'd1);
    reg_write(3'd5, 8'd0, 12'd0);
    reg_read(3'd5, 8'd0, rd); check("R10 cleared", rd, 32'd0);
    reg_write(3'd2, 8'd0, 12'd0);

    // R11 writes ignored in run mode
    @(negedge clk); run = 1'b1;
    reg_write(3'd0, 8'd9, ~f_bin(8'd9));
    reg_write(3'd1, 8'd9, ~f_en(8'd9));
    reg_read(3'd0, 8'd9, rd); check("R11 bin locked", rd, 32'(f_bin(8'd9)));
    reg_read(3'd1, 8'd9, rd); check("R11 en locked", rd, 32'(f_en(8'd9)));
    run = 1'b0;

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule